// File: doc/BRIEF.md
# Dual Data Pointer Unit

This unit holds two 16-bit data pointers for an 8051-style processor core, together with an 8-bit auxiliary control register. Bit 0 of the auxiliary register chooses which pointer is active. The core sends it requests: load the active pointer with an immediate value, increment the active pointer, and access the pointer bytes or the auxiliary register over the special-function-register (SFR) bus. The core can also apply read-modify-write operations (increment, OR, AND) to the auxiliary register. The active pointer is always driven onto the external-data address output.

Block moves load a source pointer and a destination pointer once. Software then flips between them with a single increment of the auxiliary register. Bit 1 of that register is hard-wired to zero, so the carry out of bit 0 is discarded and the upper bits are never disturbed. Bit 3 is a general-purpose software flag with no hardware effect.

Top module: `dptr_pair`

## Requirements
- R1: After reset both pointers are 16'h0000, the auxiliary register reads 8'h00, and the address output is 16'h0000.
- R2: An immediate load (`ptr_ld`) writes `ptr_ld_val` into the active pointer only. The inactive pointer keeps its value.
- R3: A pointer increment (`ptr_inc`) adds 1 to the active pointer only. The carry ripples from the low byte into the high byte, and 16'hFFFF wraps to 16'h0000.
- R4: `xaddr` always equals the currently active pointer.
- R5: SFR accesses at address `ADDR_LO` (default 8'h82) read and write the low byte of the active pointer. Accesses at `ADDR_HI` (default 8'h83) read and write its high byte. Any address other than the three mapped ones reads 8'h00.
- R6: Auxiliary bit 0 selects the active pointer: 0 selects the first pointer, 1 selects the second.
- R7: Auxiliary bit 1 always reads 0. No write, OR or increment can set it.
- R8: An auxiliary increment (`aux_op` = 2'd1) toggles bit 0 and leaves bits 7..2 unchanged.
- R9: Auxiliary bit 3 can be set and cleared by software and has no effect on pointer selection or the address output.
- R10: The auxiliary register is written directly at SFR address `ADDR_AUX` (default 8'hA2). `aux_op` = 2'd2 ORs `aux_opnd` into the register and 2'd3 ANDs it in. Bits other than 0, 1 and 3 behave as plain storage.
- R11: A pointer load or increment issued in the same cycle as a select toggle acts on the pointer selected before the toggle. The new selection takes effect in the next cycle.
- R12: Priorities within one cycle are as follows. For a pointer, load beats increment, and increment beats an SFR byte write. For the auxiliary register, a nonzero `aux_op` beats an SFR write to `ADDR_AUX`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptr_ld | input | 1 | Load the active pointer with `ptr_ld_val` |
| ptr_ld_val | input | 16 | Immediate pointer value |
| ptr_inc | input | 1 | Increment the active pointer |
| aux_op | input | 2 | Auxiliary operation: 0 none, 1 increment, 2 OR, 3 AND |
| aux_opnd | input | 8 | Operand for the OR and AND operations |
| sfr_addr | input | 8 | SFR address for reads and writes |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data, combinational from `sfr_addr` |
| xaddr | output | 16 | External data address (the active pointer) |

## Verification
Every state change is registered once, so the result of a load, increment, SFR write or auxiliary operation appears one rising edge after the request. `xaddr` and `sfr_rdata` are combinational from those registers, with no extra delay. The bench drives a request, waits for the next rising edge plus 2 ns, and then samples `xaddr`. For SFR reads it sets `sfr_addr` and samples `sfr_rdata` 1 ns later, well away from any clock edge. The same-cycle cases (R11, R12) are checked in the cycle right after the combined request, and then again after a separate toggle that exposes the other pointer.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
   typedef enum logic [1:0] {
      AUX_NOP = 2'd0,
      AUX_INC = 2'd1,
      AUX_OR  = 2'd2,
      AUX_AND = 2'd3
   } aux_op_e;

   localparam int SEL_BIT  = 0;
   localparam int ZERO_BIT = 1;
endpackage

// File: rtl/dptr_word.sv
module dptr_word #(
   parameter int DW        = 8,
   parameter bit SPLIT_INC = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld,
   input  logic [2*DW-1:0] ld_val,
   input  logic            inc,
   input  logic            wr_lo,
   input  logic            wr_hi,
   input  logic [DW-1:0]   wdata,
   output logic [2*DW-1:0] q
);
   localparam int PW = 2 * DW;

   logic [PW-1:0] inc_val;

   generate
      if (SPLIT_INC) begin : g_split
         logic [DW:0]   lo_sum;
         logic [DW-1:0] hi_sum;
         always_comb begin
            lo_sum  = {1'b0, q[DW-1:0]} + (DW+1)'(1);
            hi_sum  = q[PW-1:DW] + DW'(lo_sum[DW]);
            inc_val = {hi_sum, lo_sum[DW-1:0]};
         end
      end else begin : g_flat
         always_comb inc_val = q + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (ld) begin
         q <= ld_val;
      end else if (inc) begin
         q <= inc_val;
      end else begin
         if (wr_lo) q[DW-1:0]  <= wdata;
         if (wr_hi) q[PW-1:DW] <= wdata;
      end
   end
endmodule

// File: rtl/dptr_aux.sv
module dptr_aux
   import dptr_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    op,
   input  logic [DW-1:0] opnd,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q
);
   localparam logic [DW-1:0] KEEP_MASK = ~(DW'(1) << ZERO_BIT);

   aux_op_e       op_e;
   logic [DW-1:0] nxt;

   assign op_e = aux_op_e'(op);

   always_comb begin
      unique case (op_e)
         AUX_INC: nxt = q + DW'(1);
         AUX_OR:  nxt = q | opnd;
         AUX_AND: nxt = q & opnd;
         default: nxt = wr ? wdata : q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt & KEEP_MASK;
   end
endmodule

// File: rtl/dptr_pair.sv
module dptr_pair
   import dptr_pkg::*;
#(
   parameter int             DW        = 8,
   parameter int             AW        = 8,
   parameter logic [AW-1:0]  ADDR_LO   = 8'h82,
   parameter logic [AW-1:0]  ADDR_HI   = 8'h83,
   parameter logic [AW-1:0]  ADDR_AUX  = 8'hA2,
   parameter bit             SPLIT_INC = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ptr_ld,
   input  logic [2*DW-1:0] ptr_ld_val,
   input  logic            ptr_inc,
   input  logic [1:0]      aux_op,
   input  logic [DW-1:0]   aux_opnd,
   input  logic [AW-1:0]   sfr_addr,
   input  logic            sfr_wr,
   input  logic [DW-1:0]   sfr_wdata,
   output logic [DW-1:0]   sfr_rdata,
   output logic [2*DW-1:0] xaddr
);
   localparam int PW    = 2 * DW;
   localparam int N_PTR = 2;

   generate
      if (DW < 2) begin : g_bad_dw
         $error("dptr_pair: DW must be at least 2");
      end
      if (ADDR_LO == ADDR_HI || ADDR_LO == ADDR_AUX || ADDR_HI == ADDR_AUX) begin : g_bad_addr
         $error("dptr_pair: SFR addresses must be distinct");
      end
   endgenerate

   logic [N_PTR-1:0][PW-1:0] ptr_q;
   logic [DW-1:0]            aux_q;
   logic                     sel;
   logic                     hit_lo, hit_hi, hit_aux;

   assign sel     = aux_q[SEL_BIT];
   assign hit_lo  = (sfr_addr == ADDR_LO);
   assign hit_hi  = (sfr_addr == ADDR_HI);
   assign hit_aux = (sfr_addr == ADDR_AUX);

   generate
      for (genvar i = 0; i < N_PTR; i++) begin : g_ptr
         logic mine;
         assign mine = (sel == 1'(i));
         dptr_word #(.DW(DW), .SPLIT_INC(SPLIT_INC)) u_word (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (ptr_ld & mine),
            .ld_val (ptr_ld_val),
            .inc    (ptr_inc & mine),
            .wr_lo  (sfr_wr & hit_lo & mine),
            .wr_hi  (sfr_wr & hit_hi & mine),
            .wdata  (sfr_wdata),
            .q      (ptr_q[i])
         );
      end
   endgenerate

   dptr_aux #(.DW(DW)) u_aux (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (aux_op),
      .opnd  (aux_opnd),
      .wr    (sfr_wr & hit_aux),
      .wdata (sfr_wdata),
      .q     (aux_q)
   );

   assign xaddr = ptr_q[sel];

   always_comb begin
      if (hit_lo)       sfr_rdata = xaddr[DW-1:0];
      else if (hit_hi)  sfr_rdata = xaddr[PW-1:DW];
      else if (hit_aux) sfr_rdata = aux_q;
      else              sfr_rdata = '0;
   end
endmodule

// File: rtl/dptr_pair_chk.sv
module dptr_pair_chk #(
   parameter int DW = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ptr_ld,
   input logic [2*DW-1:0] ptr_ld_val,
   input logic            ptr_inc,
   input logic [1:0]      aux_op,
   input logic [2*DW-1:0] p0,
   input logic [2*DW-1:0] p1,
   input logic [DW-1:0]   aux,
   input logic [2*DW-1:0] xaddr
);
   AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_ld && !aux[0]) |=> (p0 == $past(ptr_ld_val))); // R2
   AST_LOAD_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_ld && aux[0]) |=> (p1 == $past(ptr_ld_val))); // R2
   AST_IDLE_FIRST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      aux[0] |=> $stable(p0)); // R11
   AST_IDLE_SECOND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !aux[0] |=> $stable(p1)); // R11
   AST_INC_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_inc && !ptr_ld && !aux[0]) |=> (p0 == $past(p0) + 16'(1))); // R3
   AST_ADDR_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      xaddr == (aux[0] ? p1 : p0)); // R4
   AST_FIXED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !aux[1]); // R7
   AST_AUX_INC_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_op == 2'd1) |=> ((aux[0] != $past(aux[0])) && (aux[7:2] == $past(aux[7:2])))); // R8
endmodule

bind dptr_pair dptr_pair_chk #(.DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ptr_ld     (ptr_ld),
   .ptr_ld_val (ptr_ld_val),
   .ptr_inc    (ptr_inc),
   .aux_op     (aux_op),
   .p0         (ptr_q[0]),
   .p1         (ptr_q[1]),
   .aux        (aux_q),
   .xaddr      (xaddr)
);

// File: tb/sim_dptr_pair.sv
`timescale 1ns/1ps
module sim_dptr_pair;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ptr_ld = 1'b0;
   logic [15:0] ptr_ld_val = '0;
   logic        ptr_inc = 1'b0;
   logic [1:0]  aux_op = 2'd0;
   logic [7:0]  aux_opnd = '0;
   logic [7:0]  sfr_addr = '0;
   logic        sfr_wr = 1'b0;
   logic [7:0]  sfr_wdata = '0;
   logic [7:0]  sfr_rdata;
   logic [15:0] xaddr;

   localparam logic [7:0] A_LO = 8'h82, A_HI = 8'h83, A_AUX = 8'hA2;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   dptr_pair u0 (
      .clk(clk), .rst_n(rst_n), .ptr_ld(ptr_ld), .ptr_ld_val(ptr_ld_val),
      .ptr_inc(ptr_inc), .aux_op(aux_op), .aux_opnd(aux_opnd),
      .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
      .sfr_rdata(sfr_rdata), .xaddr(xaddr)
   );

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
      ptr_ld = 1'b0; ptr_inc = 1'b0; aux_op = 2'd0; sfr_wr = 1'b0;
   endtask

   task automatic do_ld(input logic [15:0] v);
      ptr_ld = 1'b1; ptr_ld_val = v; tick();
   endtask

   task automatic do_inc();
      ptr_inc = 1'b1; tick();
   endtask

   task automatic do_aux(input logic [1:0] op, input logic [7:0] v);
      aux_op = op; aux_opnd = v; tick();
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1; tick();
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      sfr_addr = a; #1; d = sfr_rdata;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 xaddr after reset", xaddr, 16'h0000);
      rd(A_LO, d);  chk("R1 low byte after reset", {8'h00, d}, 16'h0000);
      rd(A_HI, d);  chk("R1 high byte after reset", {8'h00, d}, 16'h0000);
      rd(A_AUX, d); chk("R1 aux after reset", {8'h00, d}, 16'h0000);
      rd(8'h10, d); chk("R5 unmapped read", {8'h00, d}, 16'h0000);
   endtask

   task automatic t_load();
      logic [7:0] d;
      do_ld(16'h1234);
      chk("R2 load first", xaddr, 16'h1234);
      do_aux(2'd1, 8'h00);
      rd(A_AUX, d); chk("R6 select second", {8'h00, d}, 16'h0001);
      chk("R2 second untouched by load", xaddr, 16'h0000);
      do_ld(16'hABCD);
      chk("R4 xaddr shows second", xaddr, 16'hABCD);
      do_aux(2'd1, 8'h00);
      chk("R2 first kept during second load", xaddr, 16'h1234);
   endtask

   task automatic t_inc();
      do_ld(16'h00FF); do_inc();
      chk("R3 carry low to high", xaddr, 16'h0100);
      do_ld(16'hFFFF); do_inc();
      chk("R3 wrap", xaddr, 16'h0000);
      do_inc();
      chk("R3 plain inc", xaddr, 16'h0001);
      do_aux(2'd1, 8'h00);
      chk("R3 inactive not incremented", xaddr, 16'hABCD);
      do_aux(2'd1, 8'h00);
   endtask

   task automatic t_sfr();
      logic [7:0] d;
      wr(A_LO, 8'h5A); wr(A_HI, 8'hC3);
      chk("R5 byte writes first", xaddr, 16'hC35A);
      rd(A_LO, d); chk("R5 read low", {8'h00, d}, 16'h005A);
      rd(A_HI, d); chk("R5 read high", {8'h00, d}, 16'h00C3);
      do_aux(2'd1, 8'h00);
      rd(A_LO, d); chk("R5 read low second", {8'h00, d}, 16'h00CD);
      rd(A_HI, d); chk("R5 read high second", {8'h00, d}, 16'h00AB);
      wr(A_LO, 8'h11);
      chk("R5 byte write second", xaddr, 16'hAB11);
      do_aux(2'd1, 8'h00);
      chk("R5 first untouched", xaddr, 16'hC35A);
   endtask

   task automatic t_aux_bits();
      logic [7:0] d;
      wr(A_AUX, 8'hFF);
      rd(A_AUX, d); chk("R7 bit1 reads zero", {8'h00, d}, 16'h00FD);
      chk("R6 bit0 set selects second", xaddr, 16'hAB11);
      do_aux(2'd1, 8'h00);
      rd(A_AUX, d); chk("R8 inc from FD", {8'h00, d}, 16'h00FC);
      do_aux(2'd1, 8'h00);
      rd(A_AUX, d); chk("R8 inc from FC", {8'h00, d}, 16'h00FD);
      wr(A_AUX, 8'h02);
      rd(A_AUX, d); chk("R7 write bit1 ignored", {8'h00, d}, 16'h0000);
      wr(A_AUX, 8'h08);
      rd(A_AUX, d); chk("R9 flag set", {8'h00, d}, 16'h0008);
      chk("R9 flag no effect on address", xaddr, 16'hC35A);
      wr(A_AUX, 8'h00);
      rd(A_AUX, d); chk("R9 flag cleared", {8'h00, d}, 16'h0000);
   endtask

   task automatic t_aux_logic();
      logic [7:0] d;
      do_aux(2'd2, 8'hF4);
      rd(A_AUX, d); chk("R10 OR", {8'h00, d}, 16'h00F4);
      do_aux(2'd3, 8'h3F);
      rd(A_AUX, d); chk("R10 AND", {8'h00, d}, 16'h0034);
      do_aux(2'd2, 8'h02);
      rd(A_AUX, d); chk("R7 OR into bit1 ignored", {8'h00, d}, 16'h0034);
      do_aux(2'd1, 8'h00);
      rd(A_AUX, d); chk("R8 inc keeps upper", {8'h00, d}, 16'h0035);
      do_aux(2'd3, 8'hFE);
      rd(A_AUX, d); chk("R10 AND clears select", {8'h00, d}, 16'h0034);
   endtask

   task automatic t_same_cycle();
      ptr_ld = 1'b1; ptr_ld_val = 16'h7777; aux_op = 2'd1; tick();
      chk("R11 new select next cycle", xaddr, 16'hAB11);
      do_aux(2'd1, 8'h00);
      chk("R11 load went to old select", xaddr, 16'h7777);
      ptr_inc = 1'b1; aux_op = 2'd1; tick();
      chk("R11 inc with toggle, second unchanged", xaddr, 16'hAB11);
      do_aux(2'd1, 8'h00);
      chk("R11 inc went to old select", xaddr, 16'h7778);
      do_aux(2'd1, 8'h00);
   endtask

   task automatic t_priority();
      logic [7:0] d;
      ptr_ld = 1'b1; ptr_ld_val = 16'h4000; ptr_inc = 1'b1; tick();
      chk("R12 load beats inc", xaddr, 16'h4000);
      ptr_inc = 1'b1; sfr_addr = A_LO; sfr_wdata = 8'h99; sfr_wr = 1'b1; tick();
      chk("R12 inc beats byte write", xaddr, 16'h4001);
      aux_op = 2'd2; aux_opnd = 8'h80; sfr_addr = A_AUX; sfr_wdata = 8'h00; sfr_wr = 1'b1; tick();
      rd(A_AUX, d); chk("R12 aux op beats direct write", {8'h00, d}, 16'h00B5);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      t_reset();
      t_load();
      t_inc();
      t_sfr();
      t_aux_bits();
      t_aux_logic();
      t_same_cycle();
      t_priority();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule